// File: doc/BRIEF.md
# Folded Decimation Delay Chain with Block-Reversing Feedback

This block is the data-side delay network of a folded (symmetric) FIR filter. Input samples enter a forward chain of NSTG equal delay stages. A feedback section picks up samples near the middle of that chain and passes them into a reverse chain of NSTG further delay stages. Every forward and reverse stage output is brought out, so that a symmetric pre-adder can pair forward tap k with a reverse tap. All stages, forward and reverse, use the same delay length DEC_LEN (1 to 16 cycles). A longer length lets a decimating filter spend the extra cycles on additional taps.

The feedback section works in one of two modes. In reversal mode it collects each block of BLK samples into one half of a ping-pong buffer. A block is framed by a low pulse on the block strobe. While the next block is being written, the section plays the stored block back newest-first from the other half. In delay mode it is a plain delay of DEC_LEN cycles, so the reverse chain sees samples in their original order. The pickup point follows the tap-count parity. With an even count it is the output of forward stage FB_STAGE (the third stage by default). With an odd count it is that stage's input, which is the value the stage will present one stage-delay later.

Top module: `fold_dec_chain`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every forward and reverse tap reads zero. The reset also clears the ping-pong buffer contents.
- R2: Forward tap k (bits [k*DW +: DW] of `fwd_taps`, k = 0 at the input end) equals `din` delayed by (k+1)*DEC_LEN clock cycles.
- R3: With `odd_taps` = 0 (even tap count), the feedback section is fed from the output of forward stage FB_STAGE, which is `din` delayed by (FB_STAGE+1)*DEC_LEN cycles.
- R4: With `odd_taps` = 1 (odd tap count), the feedback section is fed from the input of forward stage FB_STAGE, which is `din` delayed by FB_STAGE*DEC_LEN cycles.
- R5: With `rev_off` = 1 (reversal disabled), the feedback output is the pickup value delayed by DEC_LEN cycles, in original sample order.
- R6: With `rev_off` = 1, `blk_mark_n` has no effect on any tap.
- R7: With `rev_off` = 0, the strobe `blk_mark_n` is driven low in the last cycle of each block of BLK samples. Each block is written into one buffer half. During the following block the block is read back in reverse order, one cycle behind the writes. The halves swap at every strobe.
- R8: With `rev_off` = 0, the feedback output reads zero for the whole first block after reset, because the unwritten buffer half is empty.
- R9: Reverse tap k (bits [k*DW +: DW] of `rev_taps`) equals the feedback output delayed by (k+1)*DEC_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| din | input | DW | Input sample, one per cycle |
| blk_mark_n | input | 1 | Block strobe, low in the last cycle of each block |
| rev_off | input | 1 | 1 = feedback is a plain delay, 0 = block reversal |
| odd_taps | input | 1 | 0 = even tap count pickup, 1 = odd tap count pickup |
| fwd_taps | output | NSTG*DW | Forward stage outputs, stage k at [k*DW +: DW] |
| rev_taps | output | NSTG*DW | Reverse stage outputs, stage k at [k*DW +: DW] |

## Verification
The hardest case to reach from the ports is the reversed readout crossing a block boundary at the odd pickup point. Here the buffered values are displaced by a non-block-aligned forward delay, and they emerge through several reverse stages. The bench starts the strobe cadence in the first cycle after reset and feeds a distinct value every cycle. It then predicts each reverse tap arithmetically from the block index and the position within the block, for both parities and both feedback modes. In delay mode the strobe is toggled irregularly, so that any leak from it into the taps shows up.

// File: rtl/fold_dec_pkg.sv
package fold_dec_pkg;
  typedef enum logic {
    TAP_EVEN = 1'b0,
    TAP_ODD  = 1'b1
  } tap_par_e;

  typedef enum logic {
    FB_REVERSE = 1'b0,
    FB_DELAY   = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/fold_dly_line.sv
module fold_dly_line #(
  parameter int DW  = 8,
  parameter int LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [LEN-1:0][DW-1:0] sr_q, sr_nxt;

  always_comb begin
    sr_nxt[0] = d;
    for (int i = 1; i < LEN; i++) sr_nxt[i] = sr_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  assign q = sr_q[LEN-1];

  // Checker: count cycles since reset so the LEN-deep look-back never reaches before it
  logic [4:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 5'd31) age_q <= age_q + 5'd1;
  end

  assert_delay_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(age_q) >= LEN) |-> (q == $past(d, LEN)));
endmodule

// File: rtl/fold_fb_section.sv
module fold_fb_section
  import fold_dec_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LEN = 2,
  parameter int BLK = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic          rev_off,
  input  logic          blk_mark_n,
  output logic [DW-1:0] fb_out
);
  localparam int CW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLK - 1);

  fb_mode_e mode;
  assign mode = fb_mode_e'(rev_off);

  // Delay-mode path
  logic [DW-1:0] dly_q;
  fold_dly_line #(.DW(DW), .LEN(LEN)) u_dly (
    .clk(clk), .rst_n(rst_n), .d(src), .q(dly_q)
  );

  // Reversal-mode path: ping-pong buffer, written in order, read from the other half backwards
  logic [1:0][BLK-1:0][DW-1:0] mem_q;
  logic [CW-1:0] cnt_q, cnt_nxt, rd_idx;
  logic          bank_q, bank_nxt;
  logic [DW-1:0] rd_q;
  logic          run_en;

  assign run_en = (mode == FB_REVERSE);
  assign rd_idx = LAST - cnt_q;

  always_comb begin
    cnt_nxt  = cnt_q;
    bank_nxt = bank_q;
    if (!blk_mark_n) begin
      cnt_nxt  = '0;
      bank_nxt = ~bank_q;
    end else if (cnt_q != LAST) begin
      cnt_nxt = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
      rd_q   <= '0;
    end else if (run_en) begin
      cnt_q  <= cnt_nxt;
      bank_q <= bank_nxt;
      rd_q   <= mem_q[~bank_q][rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (run_en) mem_q[bank_q][cnt_q] <= src;
  end

  assign fb_out = (mode == FB_DELAY) ? dly_q : rd_q;

  assert_blk_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev_off && !blk_mark_n) |=> (cnt_q == '0 && bank_q != $past(bank_q)));

  assert_mark_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rev_off |=> ($stable(cnt_q) && $stable(bank_q) && $stable(rd_q)));
endmodule

// File: rtl/fold_dec_chain.sv
module fold_dec_chain
  import fold_dec_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEC_LEN  = 2,
  parameter int NSTG     = 4,
  parameter int FB_STAGE = 2,
  parameter int BLK      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      din,
  input  logic               blk_mark_n,
  input  logic               rev_off,
  input  logic               odd_taps,
  output logic [NSTG*DW-1:0] fwd_taps,
  output logic [NSTG*DW-1:0] rev_taps
);
  logic [NSTG:0][DW-1:0] fwd_link;
  logic [NSTG:0][DW-1:0] rev_link;
  logic [DW-1:0]         fb_src;
  tap_par_e              parity;

  assign fwd_link[0] = din;

  for (genvar g = 0; g < NSTG; g++) begin : g_fwd
    fold_dly_line #(.DW(DW), .LEN(DEC_LEN)) u_stage (
      .clk(clk), .rst_n(rst_n), .d(fwd_link[g]), .q(fwd_link[g+1])
    );
    assign fwd_taps[g*DW +: DW] = fwd_link[g+1];
  end

  // Pickup point: stage output for even counts, stage input for odd counts
  assign parity = tap_par_e'(odd_taps);
  assign fb_src = (parity == TAP_ODD) ? fwd_link[FB_STAGE] : fwd_link[FB_STAGE+1];

  fold_fb_section #(.DW(DW), .LEN(DEC_LEN), .BLK(BLK)) u_fb (
    .clk(clk), .rst_n(rst_n), .src(fb_src), .rev_off(rev_off),
    .blk_mark_n(blk_mark_n), .fb_out(rev_link[0])
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_rev
    fold_dly_line #(.DW(DW), .LEN(DEC_LEN)) u_stage (
      .clk(clk), .rst_n(rst_n), .d(rev_link[g]), .q(rev_link[g+1])
    );
    assign rev_taps[g*DW +: DW] = rev_link[g+1];
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (fwd_taps == '0 && rev_taps == '0));
endmodule

// File: tb/fold_dec_chain_bench.sv
module fold_dec_chain_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int LEN  = 2;
  localparam int NSTG = 4;
  localparam int FBS  = 2;
  localparam int BLK  = 8;
  localparam int RUN  = 120;

  logic clk = 1'b0;
  logic rst_n, blk_mark_n, rev_off, odd_taps;
  logic [DW-1:0] din;
  logic [NSTG*DW-1:0] fwd_taps, rev_taps;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fold_dec_chain #(.DW(DW), .DEC_LEN(LEN), .NSTG(NSTG), .FB_STAGE(FBS), .BLK(BLK)) u_fold_dec_chain (
    .clk(clk), .rst_n(rst_n), .din(din), .blk_mark_n(blk_mark_n),
    .rev_off(rev_off), .odd_taps(odd_taps), .fwd_taps(fwd_taps), .rev_taps(rev_taps)
  );

  function automatic logic [DW-1:0] xv(int j);
    if (j < 0) return '0;
    return DW'((j * 29 + 7) % 256);
  endfunction

  // Feedback output after capture edge n; ds = flop depth of the pickup point
  function automatic logic [DW-1:0] fbv(int n, bit reversing, int ds);
    int b, c;
    if (n < 0) return '0;
    if (!reversing) return xv(n - ds - LEN + 1);
    b = n / BLK;
    c = n % BLK;
    if (b == 0) return '0;
    return xv(b * BLK - 1 - c - ds);
  endfunction

  task automatic chk(input string tag, input int k, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s tap %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic run_cfg(input bit roff, input bit odd);
    int ds;
    string ptag, mtag;
    ds   = odd ? FBS * LEN : (FBS + 1) * LEN;
    ptag = odd ? "R4" : "R3";
    mtag = roff ? "R5 R6" : "R7";
    rst_n = 1'b0; din = 8'hA5; blk_mark_n = 1'b1; rev_off = roff; odd_taps = odd;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NSTG; k++) begin
      chk("R1 fwd", k, fwd_taps[k*DW +: DW], '0);
      chk("R1 rev", k, rev_taps[k*DW +: DW], '0);
    end
    rst_n = 1'b1;
    for (int n = 0; n < RUN; n++) begin
      din = xv(n);
      if (roff) blk_mark_n = ((n % 3) == 1) ? 1'b0 : 1'b1;
      else      blk_mark_n = ((n % BLK) == BLK - 1) ? 1'b0 : 1'b1;
      @(negedge clk);
      for (int k = 0; k < NSTG; k++) begin
        chk("R2 fwd", k, fwd_taps[k*DW +: DW], xv(n - (k + 1) * LEN + 1));
        if (!roff && (n - (k + 1) * LEN) < BLK)
          chk({"R8 R9 ", ptag}, k, rev_taps[k*DW +: DW], fbv(n - (k + 1) * LEN, !roff, ds));
        else
          chk({mtag, " R9 ", ptag}, k, rev_taps[k*DW +: DW], fbv(n - (k + 1) * LEN, !roff, ds));
      end
    end
  endtask

  initial begin
    rst_n = 1'b1; din = '0; blk_mark_n = 1'b1; rev_off = 1'b0; odd_taps = 1'b0;
    #1;
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b1, 1'b1);
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b0, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule